// File: doc/BRIEF.md
# Pipelined Single-Precision Multiplier with Flush-to-Zero

This block multiplies two IEEE-754 single-precision words in a three-stage pipeline and can take a new operation on every cycle. Each operation carries a rounding mode and a guard word. Two kinds of denormal are never used as values. A denormal operand is read as zero. A product that lands below the normal range is returned as +0. Each of these two cases has its own flag, so software can tell them apart. A NaN result is always the all-ones word.

The pipeline has three stages. In the decode stage (`s1`), each operand is put into one of four classes: ZERO, NORM, INF or NAN. The stage also forms the sign, the 48-bit significand product and the biased exponent sum. In the round stage (`s2`), a `unique case` on the combined class selects one of four paths:
- NAN takes the invalid path.
- INF takes the signed-infinity path.
- ZERO takes the signed-zero path.
- NORM is normalised and rounded, then takes one of three exits: overflow, underflow-flush or packed normal.

The output stage (`s3`) registers the word and two flag vectors. One vector is gated by the guard bit and one is not. The ungated vector shows which flags a single multiply would raise. There is one state transition per clock edge: in → s1 → s2 → s3.

Top module: `fpm_mul`

## Requirements
- R1: An operation sampled with `in_valid` high at a rising edge appears with `out_valid` high in the cycle after the third rising edge. The pipeline accepts one operation per cycle, and results leave in issue order.
- R2: For normal operands with a normal product and mode 00, `res_data` is the product rounded to nearest-even. An exact product gives an all-zero flag vector. Flag bits are: 0 invalid, 1 overflow, 2 underflow, 3 inexact, 4 input-flush, 5 output-flush.
- R3: `rnd_mode` is encoded as 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Any rounded-away bits raise inexact (bit 3).
- R4: A denormal operand (exponent 0, nonzero fraction) is used as zero and raises input-flush (bit 4). A zero operand gives a zero carrying the XOR of the operand signs.
- R5: A rounded product whose biased exponent falls between -22 and 0 gives +0 with output-flush, underflow and inexact (bits 5, 2, 3). A product with a biased exponent below -22 gives +0 with only underflow and inexact.
- R6: A NaN operand, or infinity times zero (zero including a flushed denormal), gives 0xFFFFFFFF and raises invalid (bit 0).
- R7: A product whose rounded biased exponent reaches 255 raises overflow and inexact (bits 1, 3). The word is infinity in mode 00. In mode 01 it is the largest finite value. In mode 10 a positive product gives infinity and a negative one the largest finite value. In mode 11 a negative product gives infinity and a positive one the largest finite value. The sign is the XOR of the operand signs in every case.
- R8: Infinity times a nonzero, non-NaN operand gives infinity with the XOR sign and no flags.
- R9: Only bit 0 of `guard_word` counts. When it is 0, `res_we` and every bit of `exc_flags` are low. `calc_flags` still carries the flags of the operation. Bits 31..1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue an operation this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| guard_word | input | 32 | Guard; bit 0 enables the write |
| rnd_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | An operation completes this cycle |
| res_we | output | 1 | Destination write enable (valid and guard set) |
| res_data | output | 32 | Product word |
| exc_flags | output | 6 | Exception flags, gated by the guard |
| calc_flags | output | 6 | Exception flags the operation raises, ungated |

## Verification
The assertions assume that reset is held for at least one edge before traffic starts. The latency property assumes that reset is not applied while an operation is in flight. The flag-consistency properties hold only while `out_valid` is high. The bench drives every input on the falling edge, holds reset for several cycles first, and never resets during traffic. Its operands are hand-chosen words whose exact products put each class and each rounding exit at a known boundary: ties, the edge of the denormal band, and the maximum exponent.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = WORD_W - EXP_W - 1;
    localparam int MANT_W = FRAC_W + 1;
    localparam int PROD_W = 2 * MANT_W;
    localparam int EXPS_W = EXP_W + 2;
    localparam int FLAG_W = 6;

    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP  = (1 << EXP_W) - 1;
    localparam int DEN_SPAN = FRAC_W - 1;

    localparam int FL_INV = 0;
    localparam int FL_OVF = 1;
    localparam int FL_UNF = 2;
    localparam int FL_INX = 3;
    localparam int FL_IFZ = 4;
    localparam int FL_OFZ = 5;

    localparam logic [WORD_W-1:0] NAN_WORD = '1;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;
endpackage

// File: rtl/fpm_decode.sv
module fpm_decode
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0]        op_a,
    input  logic [WORD_W-1:0]        op_b,
    output logic                     sign_o,
    output cls_e                     cls_o,
    output logic [PROD_W-1:0]        prod_o,
    output logic signed [EXPS_W-1:0] exp_o,
    output logic                     in_flush_o
);
    localparam logic signed [EXPS_W-1:0] BIAS_S = EXPS_W'(BIAS);

    logic [WORD_W-1:0] op_w [2];
    assign op_w[0] = op_a;
    assign op_w[1] = op_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_op
        logic [EXP_W-1:0]  ex;
        logic [FRAC_W-1:0] fr;
        logic [MANT_W-1:0] man;
        logic              den;
        cls_e              cls;

        assign ex  = op_w[gi][WORD_W-2 -: EXP_W];
        assign fr  = op_w[gi][FRAC_W-1:0];
        assign man = {1'b1, fr};

        always_comb begin
            den = 1'b0;
            if (ex == '0) begin
                cls = CLS_ZERO;
                den = |fr;
            end else if (ex == '1) begin
                cls = (|fr) ? CLS_NAN : CLS_INF;
            end else begin
                cls = CLS_NORM;
            end
        end
    end

    logic any_nan, any_inf, any_zero;

    always_comb begin
        any_nan  = (g_op[0].cls == CLS_NAN)  || (g_op[1].cls == CLS_NAN);
        any_inf  = (g_op[0].cls == CLS_INF)  || (g_op[1].cls == CLS_INF);
        any_zero = (g_op[0].cls == CLS_ZERO) || (g_op[1].cls == CLS_ZERO);

        sign_o     = op_a[WORD_W-1] ^ op_b[WORD_W-1];
        in_flush_o = g_op[0].den | g_op[1].den;
        prod_o     = {{MANT_W{1'b0}}, g_op[0].man} * {{MANT_W{1'b0}}, g_op[1].man};
        exp_o      = $signed({2'b00, g_op[0].ex}) + $signed({2'b00, g_op[1].ex}) - BIAS_S;

        if (any_nan || (any_inf && any_zero)) cls_o = CLS_NAN;
        else if (any_inf)                     cls_o = CLS_INF;
        else if (any_zero)                    cls_o = CLS_ZERO;
        else                                  cls_o = CLS_NORM;
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  logic                     sign_i,
    input  cls_e                     cls_i,
    input  logic [PROD_W-1:0]        prod_i,
    input  logic signed [EXPS_W-1:0] exp_i,
    input  logic                     in_flush_i,
    input  logic [1:0]               rnd_mode_i,
    output logic [WORD_W-1:0]        word_o,
    output logic [FLAG_W-1:0]        flags_o
);
    localparam logic signed [EXPS_W-1:0] EXP_MAX = EXPS_W'(EXP_TOP);
    localparam logic signed [EXPS_W-1:0] DEN_LO  = -EXPS_W'(DEN_SPAN);
    localparam logic [WORD_W-2:0] BIG_FIN = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    rmode_e                   rm;
    logic                     hi, grd, stk, lost, inc, to_inf;
    logic [MANT_W-1:0]        kept;
    logic [MANT_W:0]          sum;
    logic [FRAC_W-1:0]        frac;
    logic signed [EXPS_W-1:0] e_n, e_f;

    always_comb begin
        rm   = rmode_e'(rnd_mode_i);
        hi   = prod_i[PROD_W-1];
        kept = hi ? prod_i[PROD_W-1 -: MANT_W] : prod_i[PROD_W-2 -: MANT_W];
        grd  = hi ? prod_i[PROD_W-1-MANT_W] : prod_i[PROD_W-2-MANT_W];
        stk  = hi ? (|prod_i[PROD_W-2-MANT_W:0]) : (|prod_i[PROD_W-3-MANT_W:0]);
        lost = grd | stk;
        e_n  = exp_i + $signed({{(EXPS_W-1){1'b0}}, hi});

        unique case (rm)
            RM_NEAR: inc = grd & (stk | kept[0]);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = ~sign_i & lost;
            RM_DOWN: inc = sign_i & lost;
        endcase

        sum = {1'b0, kept} + {{MANT_W{1'b0}}, inc};
        if (sum[MANT_W]) begin
            e_f  = e_n + EXPS_W'(1);
            frac = '0;
        end else begin
            e_f  = e_n;
            frac = sum[FRAC_W-1:0];
        end

        to_inf = (rm == RM_NEAR) || (rm == RM_UP && !sign_i) || (rm == RM_DOWN && sign_i);

        flags_o         = '0;
        flags_o[FL_IFZ] = in_flush_i;
        word_o          = '0;

        unique case (cls_i)
            CLS_NAN: begin
                word_o          = NAN_WORD;
                flags_o[FL_INV] = 1'b1;
            end
            CLS_INF: begin
                word_o = {sign_i, INF_MAG};
            end
            CLS_ZERO: begin
                word_o = {sign_i, {(WORD_W-1){1'b0}}};
            end
            CLS_NORM: begin
                if (e_f >= EXP_MAX) begin
                    flags_o[FL_OVF] = 1'b1;
                    flags_o[FL_INX] = 1'b1;
                    word_o = {sign_i, to_inf ? INF_MAG : BIG_FIN};
                end else if (e_f <= 0) begin
                    flags_o[FL_UNF] = 1'b1;
                    flags_o[FL_INX] = 1'b1;
                    flags_o[FL_OFZ] = (e_f >= DEN_LO);
                    word_o          = '0;
                end else begin
                    flags_o[FL_INX] = lost;
                    word_o = {sign_i, e_f[EXP_W-1:0], frac};
                end
            end
        endcase
    end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] guard_word,
    input  logic [1:0]        rnd_mode,
    output logic              out_valid,
    output logic              res_we,
    output logic [WORD_W-1:0] res_data,
    output logic [FLAG_W-1:0] exc_flags,
    output logic [FLAG_W-1:0] calc_flags
);
    logic unused_guard_hi;
    assign unused_guard_hi = ^guard_word[WORD_W-1:1];

    // decode stage (s1)
    logic                     d_sign, d_flush;
    cls_e                     d_cls;
    logic [PROD_W-1:0]        d_prod;
    logic signed [EXPS_W-1:0] d_exp;

    fpm_decode u_decode (
        .op_a       (op_a),
        .op_b       (op_b),
        .sign_o     (d_sign),
        .cls_o      (d_cls),
        .prod_o     (d_prod),
        .exp_o      (d_exp),
        .in_flush_o (d_flush)
    );

    logic                     s1_vld, s1_grd, s1_sign, s1_flush;
    cls_e                     s1_cls;
    logic [PROD_W-1:0]        s1_prod;
    logic signed [EXPS_W-1:0] s1_exp;
    logic [1:0]               s1_rm;

    // round stage (s2)
    logic [WORD_W-1:0] r_word;
    logic [FLAG_W-1:0] r_flags;

    fpm_round u_round (
        .sign_i     (s1_sign),
        .cls_i      (s1_cls),
        .prod_i     (s1_prod),
        .exp_i      (s1_exp),
        .in_flush_i (s1_flush),
        .rnd_mode_i (s1_rm),
        .word_o     (r_word),
        .flags_o    (r_flags)
    );

    logic              s2_vld, s2_grd;
    logic [WORD_W-1:0] s2_word;
    logic [FLAG_W-1:0] s2_flags;

    // state register process: all pipeline stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld     <= 1'b0;
            s1_grd     <= 1'b0;
            s1_sign    <= 1'b0;
            s1_flush   <= 1'b0;
            s1_cls     <= CLS_ZERO;
            s1_prod    <= '0;
            s1_exp     <= '0;
            s1_rm      <= '0;
            s2_vld     <= 1'b0;
            s2_grd     <= 1'b0;
            s2_word    <= '0;
            s2_flags   <= '0;
            out_valid  <= 1'b0;
            res_we     <= 1'b0;
            res_data   <= '0;
            calc_flags <= '0;
        end else begin
            s1_vld     <= in_valid;
            s1_grd     <= in_valid & guard_word[0];
            s1_sign    <= d_sign;
            s1_flush   <= d_flush;
            s1_cls     <= d_cls;
            s1_prod    <= d_prod;
            s1_exp     <= d_exp;
            s1_rm      <= rnd_mode;
            s2_vld     <= s1_vld;
            s2_grd     <= s1_grd;
            s2_word    <= r_word;
            s2_flags   <= s1_vld ? r_flags : '0;
            out_valid  <= s2_vld;
            res_we     <= s2_grd;
            res_data   <= s2_word;
            calc_flags <= s2_flags;
        end
    end

    // output process: guard gating of the flag vector
    always_comb begin
        exc_flags = res_we ? calc_flags : '0;
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));
    a_r9_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> out_valid);
    a_r9_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !res_we |-> (exc_flags == '0));
    a_r6_nan_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && calc_flags[FL_INV]) |-> (res_data == NAN_WORD));
    a_r7_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && calc_flags[FL_OVF]) |-> (calc_flags[FL_INX] && !calc_flags[FL_UNF]));
    a_r5_ofz_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && calc_flags[FL_OFZ]) |-> (calc_flags[FL_UNF] && res_data == '0));
endmodule

// File: tb/fpm_mul_bench.sv
module fpm_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, guard_word = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid, res_we;
    logic [31:0] res_data;
    logic [5:0]  exc_flags, calc_flags;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [5:0] F_INV = 6'h01, F_OVF = 6'h02, F_UNF = 6'h04,
                           F_INX = 6'h08, F_IFZ = 6'h10, F_OFZ = 6'h20;

    always #5 clk = ~clk;

    fpm_mul u_fpm_mul (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .guard_word (guard_word),
        .rnd_mode   (rnd_mode),
        .out_valid  (out_valid),
        .res_we     (res_we),
        .res_data   (res_data),
        .exc_flags  (exc_flags),
        .calc_flags (calc_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, b, g, input logic [1:0] m);
        in_valid   = 1'b1;
        op_a       = a;
        op_b       = b;
        guard_word = g;
        rnd_mode   = m;
    endtask

    // issue one op, check that it is absent after two edges and present after three
    task automatic run_op(input string tag, input logic [31:0] a, b, g, input logic [1:0] m,
                          input logic [31:0] exp_w, input logic [5:0] exp_f);
        @(negedge clk);
        drive(a, b, g, m);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({tag, " R1 not early"}, {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        chk({tag, " R1 valid"}, {31'b0, out_valid}, 32'd1);
        chk({tag, " R9 we"}, {31'b0, res_we}, {31'b0, g[0]});
        if (g[0]) chk({tag, " data"}, res_data, exp_w);
        chk({tag, " calc flags"}, {26'b0, calc_flags}, {26'b0, exp_f});
        chk({tag, " R9 exc flags"}, {26'b0, exc_flags}, g[0] ? {26'b0, exp_f} : 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset valid", {31'b0, out_valid}, 32'd0);
        chk("R9 reset we", {31'b0, res_we}, 32'd0);
        chk("R9 reset flags", {26'b0, exc_flags}, 32'd0);
    endtask

    task automatic t_basic();
        run_op("R2 -3x1",   32'hC0400000, 32'h3F800000, 32'd1, 2'b00, 32'hC0400000, 6'h00);
        run_op("R2 3x-3",   32'h40400000, 32'hC0400000, 32'd1, 2'b00, 32'hC1100000, 6'h00);
        run_op("R2 3xmin",  32'h40400000, 32'h00800000, 32'd1, 2'b00, 32'h01400000, 6'h00);
    endtask

    task automatic t_round();
        run_op("R3 tie near",  32'h3F800800, 32'h3F800800, 32'd1, 2'b00, 32'h3F801000, F_INX);
        run_op("R3 tie zero",  32'h3F800800, 32'h3F800800, 32'd1, 2'b01, 32'h3F801000, F_INX);
        run_op("R3 tie up",    32'h3F800800, 32'h3F800800, 32'd1, 2'b10, 32'h3F801001, F_INX);
        run_op("R3 neg down",  32'hBF800800, 32'h3F800800, 32'd1, 2'b11, 32'hBF801001, F_INX);
        run_op("R3 neg up",    32'hBF800800, 32'h3F800800, 32'd1, 2'b10, 32'hBF801000, F_INX);
    endtask

    task automatic t_in_flush();
        run_op("R4 denorm in", 32'h40400000, 32'h00400000, 32'd1, 2'b00, 32'h00000000, F_IFZ);
        run_op("R4 neg zero",  32'hC0400000, 32'h00000000, 32'd1, 2'b00, 32'h80000000, 6'h00);
    endtask

    task automatic t_out_flush();
        run_op("R5 ofz",       32'h3F000000, 32'h00800000, 32'd1, 2'b00, 32'h0, F_OFZ | F_UNF | F_INX);
        run_op("R5 deep sq",   32'h00800000, 32'h00800000, 32'd1, 2'b00, 32'h0, F_UNF | F_INX);
        run_op("R5 deep neg",  32'h00C00000, 32'h80800000, 32'd1, 2'b00, 32'h0, F_UNF | F_INX);
    endtask

    task automatic t_invalid();
        run_op("R6 inf x 0",   32'h7F800000, 32'h00000000, 32'd1, 2'b00, 32'hFFFFFFFF, F_INV);
        run_op("R6 nan in",    32'h7FC00000, 32'h3F800000, 32'd1, 2'b00, 32'hFFFFFFFF, F_INV);
    endtask

    task automatic t_overflow();
        run_op("R7 near",   32'h7F7FFFFF, 32'h7F7FFFFF, 32'd1, 2'b00, 32'h7F800000, F_OVF | F_INX);
        run_op("R7 zero",   32'h7F7FFFFF, 32'h7F7FFFFF, 32'd1, 2'b01, 32'h7F7FFFFF, F_OVF | F_INX);
        run_op("R7 up pos", 32'h7F7FFFFF, 32'h7F7FFFFF, 32'd1, 2'b10, 32'h7F800000, F_OVF | F_INX);
        run_op("R7 dn pos", 32'h7F7FFFFF, 32'h7F7FFFFF, 32'd1, 2'b11, 32'h7F7FFFFF, F_OVF | F_INX);
        run_op("R7 up neg", 32'hFF7FFFFF, 32'h7F7FFFFF, 32'd1, 2'b10, 32'hFF7FFFFF, F_OVF | F_INX);
        run_op("R7 dn neg", 32'hFF7FFFFF, 32'h7F7FFFFF, 32'd1, 2'b11, 32'hFF800000, F_OVF | F_INX);
    endtask

    task automatic t_inf();
        run_op("R8 inf x -inf", 32'h7F800000, 32'hFF800000, 32'd1, 2'b00, 32'hFF800000, 6'h00);
        run_op("R8 inf x 3",    32'h7F800000, 32'h40400000, 32'd1, 2'b00, 32'h7F800000, 6'h00);
    endtask

    task automatic t_guard();
        run_op("R9 guard 2",    32'h3F000000, 32'h00800000, 32'h00000002, 2'b00, 32'h0, F_OFZ | F_UNF | F_INX);
        run_op("R9 guard hi",   32'h7F800000, 32'h00000000, 32'hFFFFFFFE, 2'b00, 32'h0, F_INV);
        run_op("R9 guard b0",   32'h40400000, 32'h00800000, 32'h80000001, 2'b00, 32'h01400000, 6'h00);
    endtask

    task automatic t_pipe();
        @(negedge clk); drive(32'hC0400000, 32'h3F800000, 32'd1, 2'b00);
        @(negedge clk); drive(32'h40400000, 32'hC0400000, 32'd0, 2'b00);
        @(negedge clk); drive(32'h7F800000, 32'hFF800000, 32'd1, 2'b00);
        @(negedge clk); in_valid = 1'b0;
        chk("R1 pipe 1 valid", {31'b0, out_valid}, 32'd1);
        chk("R1 pipe 1 data", res_data, 32'hC0400000);
        @(negedge clk);
        chk("R1 pipe 2 valid", {31'b0, out_valid}, 32'd1);
        chk("R9 pipe 2 we", {31'b0, res_we}, 32'd0);
        @(negedge clk);
        chk("R1 pipe 3 data", res_data, 32'hFF800000);
        chk("R1 pipe 3 we", {31'b0, res_we}, 32'd1);
        @(negedge clk);
        chk("R1 pipe drained", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_round();
        t_in_flush();
        t_out_flush();
        t_invalid();
        t_overflow();
        t_inf();
        t_guard();
        t_pipe();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule